// File: doc/BRIEF.md
# Sigma-Delta Converter Mode Sequencer

This block is the control state machine that sits between the register file of a sigma-delta converter and its modulator and digital filter. A 3-bit mode code selects continuous conversion, one-shot conversion, idle, power-down or one of four calibrations. The block runs the modulator, holds the filter in reset, or requests power-down as the mode requires, and it loads the data register and drives the active-low ready flag. Calibration results are written into a small bank of per-channel offset and full-scale coefficient registers.

Time is measured in two ways. A one-clock `conv_tick` pulse marks the end of each conversion period, so period counts do not depend on the output data rate. A parameterised count of system clocks gives the oscillator settling interval of a one-shot conversion. The converted word arrives on `result_in` and is sampled on the tick that completes a conversion or calibration.

A new mode write always aborts the current activity and starts the new mode from its beginning. An aborted calibration writes no coefficient.

Top module: `sd_mode_seq`

## Requirements
- R1: After reset the block is in continuous conversion with `mod_run`=1, `filt_rst`=0, `pwr_dn`=0, `rdy_n`=1, `data_q`=0 and every coefficient register 0.
- R2: In continuous conversion (mode code 000) the first result is loaded on the 2nd `conv_tick` after reset, after a mode write, or after a `cfg_wr` pulse; every later tick loads a result. A load sets `data_q` to `result_in`, pulses `data_ld` for one cycle and drives `rdy_n` low.
- R3: A `data_rd` pulse drives `rdy_n` high on the next cycle, unless a load or calibration end happens in that same cycle.
- R4: Single conversion (code 001) first waits exactly `SETTLE_CLKS` clocks, with `mod_run` low and any ticks ignored. It then counts 2 ticks, loads the result, drives `rdy_n` low and enters power-down (`pwr_dn`=1).
- R5: After a single conversion, `data_q` and `rdy_n`=0 are held through further ticks until `data_rd` or a new mode write.
- R6: Idle (code 010) gives `filt_rst`=1 and `mod_run`=0, and ticks load nothing. Power-down (code 011) gives `pwr_dn`=1. At most one of `mod_run`, `filt_rst` and `pwr_dn` is high at any time.
- R7: A calibration (codes 100 to 111) drives `rdy_n` high when it starts and low when it ends, and then leaves the block in idle.
- R8: A calibration takes 2 ticks. The one exception is internal full-scale (code 101) with gain code not 0 (gain code 0 is x1), which takes 4 ticks.
- R9: Zero-scale calibrations (codes 100 and 110) write the final `result_in` into the offset register of the channel latched at the mode write. Full-scale calibrations (101 and 111) write it into that channel's full-scale register. No other register changes.
- R10: Code 101 with gain code 7 (x128) is rejected: `cal_err` pulses for one cycle, the block goes to idle and no coefficient changes. System full-scale (111) at gain code 7 is accepted.
- R11: A mode write during a calibration aborts it without writing a coefficient. Writing the same calibration code again restarts its tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe: write `mode_in` |
| mode_in | input | 3 | Mode code |
| gain_in | input | 3 | Gain code, 0 = x1 through 7 = x128 |
| chan_in | input | CHW | Channel select, latched on `mode_wr` or `cfg_wr` |
| cfg_wr | input | 1 | Configuration or channel write; restarts continuous conversion |
| conv_tick | input | 1 | End of one conversion period (filter done) |
| result_in | input | DW | Filter output word |
| data_rd | input | 1 | Data register read strobe |
| mod_run | output | 1 | Modulator and filter running |
| filt_rst | output | 1 | Modulator and filter held in reset, clocks running |
| pwr_dn | output | 1 | Power-down request |
| rdy_n | output | 1 | Ready flag, active low |
| data_q | output | DW | Data register |
| data_ld | output | 1 | One-cycle pulse after a data register load |
| cal_err | output | 1 | One-cycle pulse on a rejected calibration |
| off_all | output | NCH*DW | Offset registers, channel c at bits [c*DW +: DW] |
| fs_all | output | NCH*DW | Full-scale registers, same packing |

## Verification
All results come from registers updated on the clock edge that consumes the strobe. `data_q`, `data_ld`, `rdy_n` and the coefficients are therefore due one edge after the completing `conv_tick`, and mode outputs and `cal_err` one edge after `mode_wr`. The single-shot settling window ends exactly `SETTLE_CLKS` edges after the mode write. The bench drives every strobe for one full cycle starting at a falling edge, and it samples at the following falling edge, or at a counted number of falling edges for the settling window. Every check therefore reads the value from the first edge at which it is due.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;

    localparam logic [2:0] MODE_CONT   = 3'b000;
    localparam logic [2:0] MODE_SINGLE = 3'b001;
    localparam logic [2:0] MODE_IDLE   = 3'b010;
    localparam logic [2:0] MODE_PDN    = 3'b011;
    localparam logic [2:0] MODE_IZS    = 3'b100;
    localparam logic [2:0] MODE_IFS    = 3'b101;
    localparam logic [2:0] MODE_SZS    = 3'b110;
    localparam logic [2:0] MODE_SFS    = 3'b111;

    localparam logic [2:0] GAIN_UNITY  = 3'd0;
    localparam logic [2:0] GAIN_TOP    = 3'd7;

    typedef enum logic [2:0] {
        ST_CONT,
        ST_SETTLE,
        ST_SCONV,
        ST_PDN,
        ST_IDLE,
        ST_CAL
    } seq_st_e;

endpackage

// File: rtl/sd_settle_timer.sv
module sd_settle_timer #(
    parameter int LIM = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done = en && !clr && (cnt_q == CW'(LIM - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !en) begin
            cnt_d = '0;
        end else if (done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_coef_bank.sv
module sd_coef_bank #(
    parameter int DW  = 20,
    parameter int NCH = 3,
    parameter int CHW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_off,
    input  logic              wr_fs,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [DW-1:0]     wr_val,
    output logic [NCH*DW-1:0] off_all,
    output logic [NCH*DW-1:0] fs_all
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] off_d, off_q, fs_d, fs_q;
        logic          hit;

        assign hit = (wr_ch == CHW'(g));

        always_comb begin
            off_d = off_q;
            fs_d  = fs_q;
            if (wr_off && hit) off_d = wr_val;
            if (wr_fs  && hit) fs_d  = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q <= '0;
                fs_q  <= '0;
            end else begin
                off_q <= off_d;
                fs_q  <= fs_d;
            end
        end

        assign off_all[g*DW +: DW] = off_q;
        assign fs_all[g*DW +: DW]  = fs_q;
    end
endmodule

// File: rtl/sd_seq_ctrl.sv
module sd_seq_ctrl
    import sd_seq_pkg::*;
#(
    parameter int DW  = 20,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_wr,
    input  logic [2:0]     mode_in,
    input  logic [2:0]     gain_in,
    input  logic [CHW-1:0] chan_in,
    input  logic           cfg_wr,
    input  logic           conv_tick,
    input  logic [DW-1:0]  result_in,
    input  logic           data_rd,
    input  logic           settle_done,
    output logic           settle_en,
    output logic           mod_run,
    output logic           filt_rst,
    output logic           pwr_dn,
    output logic           in_cal,
    output logic           rdy_n,
    output logic [DW-1:0]  data_q,
    output logic           data_ld,
    output logic           cal_err,
    output logic           coef_wr_off,
    output logic           coef_wr_fs,
    output logic [CHW-1:0] coef_ch,
    output logic [DW-1:0]  coef_val
);
    typedef struct packed {
        seq_st_e        st;
        logic [2:0]     cnt;
        logic [2:0]     need;
        logic           first;
        logic           fs_kind;
        logic [CHW-1:0] chan;
        logic           rdy_n;
        logic [DW-1:0]  data;
        logic           ld;
        logic           err;
    } seq_reg_t;

    seq_reg_t r_d, r_q;
    logic     wr_off_d, wr_fs_d;
    logic     cont_last;

    assign cont_last = r_q.first ? (r_q.cnt == 3'd1) : 1'b1;

    always_comb begin
        r_d      = r_q;
        r_d.ld   = 1'b0;
        r_d.err  = 1'b0;
        wr_off_d = 1'b0;
        wr_fs_d  = 1'b0;

        if (data_rd) r_d.rdy_n = 1'b1;

        if (mode_wr) begin
            r_d.cnt     = '0;
            r_d.rdy_n   = 1'b1;
            r_d.chan    = chan_in;
            r_d.fs_kind = mode_in[0];
            r_d.first   = 1'b1;
            r_d.need    = 3'd2;
            case (mode_in)
                MODE_CONT:   r_d.st = ST_CONT;
                MODE_SINGLE: r_d.st = ST_SETTLE;
                MODE_IDLE:   r_d.st = ST_IDLE;
                MODE_PDN:    r_d.st = ST_PDN;
                default: begin
                    if (mode_in == MODE_IFS && gain_in == GAIN_TOP) begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st = ST_CAL;
                        if (mode_in == MODE_IFS && gain_in != GAIN_UNITY)
                            r_d.need = 3'd4;
                    end
                end
            endcase
        end else begin
            case (r_q.st)
                ST_CONT: begin
                    if (cfg_wr) begin
                        r_d.cnt   = '0;
                        r_d.first = 1'b1;
                        r_d.chan  = chan_in;
                    end else if (conv_tick) begin
                        if (cont_last) begin
                            r_d.cnt   = '0;
                            r_d.first = 1'b0;
                            r_d.data  = result_in;
                            r_d.ld    = 1'b1;
                            r_d.rdy_n = 1'b0;
                        end else begin
                            r_d.cnt = r_q.cnt + 3'd1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        r_d.st  = ST_SCONV;
                        r_d.cnt = '0;
                    end
                end
                ST_SCONV: begin
                    if (conv_tick) begin
                        if (r_q.cnt == 3'd1) begin
                            r_d.st    = ST_PDN;
                            r_d.cnt   = '0;
                            r_d.data  = result_in;
                            r_d.ld    = 1'b1;
                            r_d.rdy_n = 1'b0;
                        end else begin
                            r_d.cnt = r_q.cnt + 3'd1;
                        end
                    end
                end
                ST_CAL: begin
                    if (conv_tick) begin
                        if (r_q.cnt == r_q.need - 3'd1) begin
                            r_d.st    = ST_IDLE;
                            r_d.cnt   = '0;
                            r_d.rdy_n = 1'b0;
                            wr_off_d  = !r_q.fs_kind;
                            wr_fs_d   = r_q.fs_kind;
                        end else begin
                            r_d.cnt = r_q.cnt + 3'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_CONT;
            r_q.cnt     <= '0;
            r_q.need    <= 3'd2;
            r_q.first   <= 1'b1;
            r_q.fs_kind <= 1'b0;
            r_q.chan    <= '0;
            r_q.rdy_n   <= 1'b1;
            r_q.data    <= '0;
            r_q.ld      <= 1'b0;
            r_q.err     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign settle_en   = (r_q.st == ST_SETTLE);
    assign mod_run     = (r_q.st == ST_CONT) || (r_q.st == ST_SCONV) || (r_q.st == ST_CAL);
    assign filt_rst    = (r_q.st == ST_IDLE) || (r_q.st == ST_SETTLE);
    assign pwr_dn      = (r_q.st == ST_PDN);
    assign in_cal      = (r_q.st == ST_CAL);
    assign rdy_n       = r_q.rdy_n;
    assign data_q      = r_q.data;
    assign data_ld     = r_q.ld;
    assign cal_err     = r_q.err;
    assign coef_wr_off = wr_off_d;
    assign coef_wr_fs  = wr_fs_d;
    assign coef_ch     = r_q.chan;
    assign coef_val    = result_in;
endmodule

// File: rtl/sd_mode_seq.sv
module sd_mode_seq #(
    parameter int DW          = 20,
    parameter int NCH         = 3,
    parameter int SETTLE_CLKS = 100000,
    localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_in,
    input  logic [2:0]        gain_in,
    input  logic [CHW-1:0]    chan_in,
    input  logic              cfg_wr,
    input  logic              conv_tick,
    input  logic [DW-1:0]     result_in,
    input  logic              data_rd,
    output logic              mod_run,
    output logic              filt_rst,
    output logic              pwr_dn,
    output logic              rdy_n,
    output logic [DW-1:0]     data_q,
    output logic              data_ld,
    output logic              cal_err,
    output logic [NCH*DW-1:0] off_all,
    output logic [NCH*DW-1:0] fs_all
);
    logic           settle_en, settle_done, in_cal;
    logic           coef_wr_off, coef_wr_fs;
    logic [CHW-1:0] coef_ch;
    logic [DW-1:0]  coef_val;

    sd_settle_timer #(.LIM(SETTLE_CLKS)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_wr),
        .en    (settle_en),
        .done  (settle_done)
    );

    sd_seq_ctrl #(.DW(DW), .CHW(CHW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_in     (mode_in),
        .gain_in     (gain_in),
        .chan_in     (chan_in),
        .cfg_wr      (cfg_wr),
        .conv_tick   (conv_tick),
        .result_in   (result_in),
        .data_rd     (data_rd),
        .settle_done (settle_done),
        .settle_en   (settle_en),
        .mod_run     (mod_run),
        .filt_rst    (filt_rst),
        .pwr_dn      (pwr_dn),
        .in_cal      (in_cal),
        .rdy_n       (rdy_n),
        .data_q      (data_q),
        .data_ld     (data_ld),
        .cal_err     (cal_err),
        .coef_wr_off (coef_wr_off),
        .coef_wr_fs  (coef_wr_fs),
        .coef_ch     (coef_ch),
        .coef_val    (coef_val)
    );

    sd_coef_bank #(.DW(DW), .NCH(NCH), .CHW(CHW)) coef_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_off  (coef_wr_off),
        .wr_fs   (coef_wr_fs),
        .wr_ch   (coef_ch),
        .wr_val  (coef_val),
        .off_all (off_all),
        .fs_all  (fs_all)
    );
endmodule

// File: rtl/sd_mode_seq_chk.sv
module sd_mode_seq_chk #(
    parameter int DW  = 20,
    parameter int NCH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic              data_rd,
    input logic              mod_run,
    input logic              filt_rst,
    input logic              pwr_dn,
    input logic              rdy_n,
    input logic [DW-1:0]     data_q,
    input logic              data_ld,
    input logic              cal_err,
    input logic              in_cal,
    input logic [NCH*DW-1:0] off_all,
    input logic [NCH*DW-1:0] fs_all
);
    assert_ctrl_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_run, filt_rst, pwr_dn}));

    assert_load_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_ld |-> !rdy_n);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ld |-> $stable(data_q));

    assert_read_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(data_rd) && !data_ld && !$past(in_cal)) |-> rdy_n);

    assert_off_from_cal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(off_all) |-> $past(in_cal));

    assert_fs_from_cal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fs_all) |-> $past(in_cal));

    assert_reject_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> (filt_rst && !in_cal));

    assert_cal_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_cal) && !$past(mode_wr)) |-> (!rdy_n && filt_rst));
endmodule

bind sd_mode_seq sd_mode_seq_chk #(.DW(DW), .NCH(NCH)) chk_i (.*);

// File: tb/sd_mode_seq_tb_top.sv
module sd_mode_seq_tb_top;
    localparam int DW  = 20;
    localparam int NCH = 3;
    localparam int SC  = 10;
    localparam int CHW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_wr = 1'b0;
    logic [2:0]        mode_in = '0;
    logic [2:0]        gain_in = '0;
    logic [CHW-1:0]    chan_in = '0;
    logic              cfg_wr = 1'b0;
    logic              conv_tick = 1'b0;
    logic [DW-1:0]     result_in = '0;
    logic              data_rd = 1'b0;
    logic              mod_run, filt_rst, pwr_dn, rdy_n, data_ld, cal_err;
    logic [DW-1:0]     data_q;
    logic [NCH*DW-1:0] off_all, fs_all;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sd_mode_seq #(.DW(DW), .NCH(NCH), .SETTLE_CLKS(SC)) dut_i (.*);

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] off_of(input int c);
        return off_all[c*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] fs_of(input int c);
        return fs_all[c*DW +: DW];
    endfunction

    task automatic tick(input logic [DW-1:0] v);
        @(negedge clk); conv_tick = 1'b1; result_in = v;
        @(negedge clk); conv_tick = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] m, input logic [2:0] g, input logic [CHW-1:0] c);
        @(negedge clk); mode_wr = 1'b1; mode_in = m; gain_in = g; chan_in = c;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic rd_data();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
        chk(data_q == '0, "R1 data_q", data_q, 0);
        chk(mod_run && !filt_rst && !pwr_dn, "R1 controls", {mod_run, filt_rst, pwr_dn}, 3'b100);
        chk(off_all == '0 && fs_all == '0, "R1 coefficients", off_all ^ fs_all, 0);
    endtask

    task automatic t_continuous();
        tick(20'h11111);
        chk(!data_ld && rdy_n, "R2 no result after 1 tick", {data_ld, rdy_n}, 2'b01);
        tick(20'h22222);
        chk(data_q == 20'h22222 && data_ld && !rdy_n, "R2 first result", data_q, 20'h22222);
        @(negedge clk);
        chk(!data_ld, "R2 load pulse one cycle", data_ld, 0);
        tick(20'h33333);
        chk(data_q == 20'h33333, "R2 every tick", data_q, 20'h33333);
        rd_data();
        chk(rdy_n == 1'b1, "R3 read sets rdy_n", rdy_n, 1);
        @(negedge clk); cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        tick(20'h44444);
        chk(data_q == 20'h33333, "R2 cfg_wr restarts count", data_q, 20'h33333);
        tick(20'h55555);
        chk(data_q == 20'h55555, "R2 second tick after cfg_wr", data_q, 20'h55555);
    endtask

    task automatic t_single();
        wr_mode(3'b001, 3'd0, 2'd0);
        chk(filt_rst && !mod_run && !pwr_dn && rdy_n, "R4 settling", {filt_rst, mod_run}, 2'b10);
        tick(20'h0AAAA);
        repeat (7) @(negedge clk);
        chk(!mod_run, "R4 still settling at SC-1", mod_run, 0);
        @(negedge clk);
        chk(mod_run, "R4 converting at SC", mod_run, 1);
        tick(20'h0BBBB);
        chk(!data_ld && data_q == 20'h55555, "R4 settle tick ignored", data_q, 20'h55555);
        tick(20'h0CCCC);
        chk(data_q == 20'h0CCCC && !rdy_n && pwr_dn, "R4 single result", data_q, 20'h0CCCC);
        tick(20'h0DDDD);
        tick(20'h0EEEE);
        chk(data_q == 20'h0CCCC && !rdy_n, "R5 result held", data_q, 20'h0CCCC);
        rd_data();
        chk(rdy_n && data_q == 20'h0CCCC, "R5 read releases ready", rdy_n, 1);
    endtask

    task automatic t_idle_pdn();
        wr_mode(3'b010, 3'd0, 2'd0);
        chk(filt_rst && !mod_run && !pwr_dn, "R6 idle controls", {mod_run, filt_rst, pwr_dn}, 3'b010);
        tick(20'h12345);
        tick(20'h12346);
        chk(!data_ld && data_q == 20'h0CCCC, "R6 idle ignores ticks", data_q, 20'h0CCCC);
        wr_mode(3'b011, 3'd0, 2'd0);
        chk(pwr_dn && !mod_run && !filt_rst, "R6 power-down", {mod_run, filt_rst, pwr_dn}, 3'b001);
    endtask

    task automatic t_cal();
        // internal zero-scale, channel 1, 2 ticks
        wr_mode(3'b100, 3'd2, 2'd1);
        chk(rdy_n && mod_run, "R7 cal start", rdy_n, 1);
        tick(20'h00A01);
        chk(off_of(1) == '0, "R8 zero-scale not done after 1", off_of(1), 0);
        tick(20'h00A02);
        chk(off_of(1) == 20'h00A02 && !rdy_n && filt_rst, "R7 R9 offset ch1", off_of(1), 20'h00A02);
        chk(fs_all == '0 && off_of(0) == '0 && off_of(2) == '0, "R9 others untouched", fs_all, 0);
        // internal full-scale, gain code 3, channel 2, 4 ticks
        wr_mode(3'b101, 3'd3, 2'd2);
        tick(20'h00B01); tick(20'h00B02); tick(20'h00B03);
        chk(fs_of(2) == '0 && !filt_rst, "R8 full-scale gain>1 running at 3", fs_of(2), 0);
        tick(20'h00B04);
        chk(fs_of(2) == 20'h00B04 && !rdy_n, "R8 full-scale gain>1 after 4", fs_of(2), 20'h00B04);
        // internal full-scale, gain x1, channel 0, 2 ticks
        wr_mode(3'b101, 3'd0, 2'd0);
        tick(20'h00C01); tick(20'h00C02);
        chk(fs_of(0) == 20'h00C02, "R8 full-scale gain x1 after 2", fs_of(0), 20'h00C02);
        // system zero-scale, channel 0
        wr_mode(3'b110, 3'd5, 2'd0);
        tick(20'h00D01); tick(20'h00D02);
        chk(off_of(0) == 20'h00D02 && fs_of(0) == 20'h00C02, "R9 system offset ch0", off_of(0), 20'h00D02);
        // system full-scale, channel 1, gain x128 accepted
        wr_mode(3'b111, 3'd7, 2'd1);
        chk(!cal_err && mod_run, "R10 system full-scale x128 accepted", cal_err, 0);
        tick(20'h00E01); tick(20'h00E02);
        chk(fs_of(1) == 20'h00E02 && off_of(1) == 20'h00A02, "R9 system full-scale ch1", fs_of(1), 20'h00E02);
    endtask

    task automatic t_reject();
        wr_mode(3'b101, 3'd7, 2'd1);
        chk(cal_err && filt_rst && !mod_run, "R10 rejected", cal_err, 1);
        @(negedge clk);
        chk(!cal_err, "R10 error one cycle", cal_err, 0);
        tick(20'h0F001); tick(20'h0F002); tick(20'h0F003); tick(20'h0F004);
        chk(fs_of(1) == 20'h00E02, "R10 no coefficient write", fs_of(1), 20'h00E02);
    endtask

    task automatic t_abort();
        wr_mode(3'b100, 3'd0, 2'd2);
        tick(20'h01101);
        wr_mode(3'b010, 3'd0, 2'd2);
        tick(20'h01102); tick(20'h01103);
        chk(off_of(2) == '0, "R11 aborted cal writes nothing", off_of(2), 0);
        wr_mode(3'b100, 3'd0, 2'd2);
        tick(20'h01201);
        wr_mode(3'b100, 3'd0, 2'd2);
        tick(20'h01202);
        chk(off_of(2) == '0 && mod_run, "R11 restart count", off_of(2), 0);
        tick(20'h01203);
        chk(off_of(2) == 20'h01203, "R11 restarted cal completes", off_of(2), 20'h01203);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_continuous();
        t_single();
        t_idle_pdn();
        t_cal();
        t_reject();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule